// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is the bulk-transfer front end of a keyed configuration store. Software places a 16-byte descriptor in system memory and writes the descriptor's bus address into a split 64-bit doorbell. The engine then fetches the descriptor over a byte-wide memory master port. It can select a new store item before it starts. It then copies item bytes to memory, skips over them, or zero-fills the destination. At the end it writes a completion word back over the descriptor's control field.

The engine owns the current key and byte offset of the store. These are exported on `cur_key` and `cur_off` so that the store can return the addressed byte combinationally, and so that a separate read port can share the same cursor. Reading the doorbell window returns a fixed identification constant. A host uses it to probe for the engine.

The memory port uses a request/acknowledge handshake, with the response acting as the ready. The engine raises `mem_req` with `mem_we`, `mem_addr` and `mem_wdata`, and holds all four unchanged until the cycle in which `mem_ack` or `mem_err` is high. A response pulse completes exactly one byte. The engine may present its next request in the following cycle. The memory side stalls the engine simply by withholding the response.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset the engine is idle: `busy` is 0, `mem_req` is 0, the cursor holds key 0 at offset 0, and the stored doorbell address is 0.
- R2: A doorbell write takes effect only in one of three forms. A 4-byte write at offset 0 stores `{db_wr_data[31:0], 32'h0}` as the address. A 4-byte write at offset 4 starts a transfer at the stored address ORed with `db_wr_data[31:0]`. An 8-byte write at offset 0 starts a transfer at `db_wr_data`. Any other size or offset has no effect.
- R3: A doorbell read of `db_rd_size` bytes at `db_rd_off` returns, right-aligned, those bytes of the constant 0x51454D5520434647, with byte 0 being 0x51. A read that runs past byte 7, or has size 0, returns 0.
- R4: The stored doorbell address is cleared to 0 whenever a transfer starts. Doorbell writes arriving while `busy` is 1 are ignored.
- R5: The descriptor is fetched as 16 bytes in ascending address order and read big-endian: bytes 0..3 are the control word, bytes 4..7 the length, and bytes 8..15 the destination address.
- R6: When control bit 3 (value 0x08) is set, the cursor key becomes control[31:16] and the offset becomes 0 before any data moves.
- R7: Control bit 1 (0x02) requests a read and has priority over bit 2 (0x04), which requests a skip. With neither bit set, no data moves.
- R8: A read writes the item byte at the cursor offset to the destination address, one byte per response. The offset and the destination each advance by one.
- R9: A skip writes nothing to memory and advances the offset by min(remaining length, item length − offset) in one step.
- R10: When the selected item is absent, or the offset has reached its length, all the remaining length is consumed. A read writes zero bytes for it, and the offset does not move.
- R11: A descriptor fetch error, or an error response to a data write, ends the transfer with status 1. A failed data byte still advances the offset. A clean transfer gives status 0. The status is written as 4 big-endian bytes at descriptor offset 0.
- R12: While `mem_req` is 1 without a response, the next cycle keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged.
- R13: `busy` rises in the cycle after the starting doorbell write and falls after the response to the last status byte. `mem_req` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr_en | input | 1 | Doorbell write strobe |
| db_wr_off | input | 3 | Doorbell write byte offset |
| db_wr_size | input | 4 | Doorbell write size in bytes |
| db_wr_data | input | 64 | Doorbell write data, right-aligned |
| db_rd_off | input | 3 | Doorbell read byte offset |
| db_rd_size | input | 4 | Doorbell read size in bytes |
| db_rd_data | output | 64 | Identification slice, combinational |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Successful response |
| mem_err | input | 1 | Error response |
| cur_key | output | 16 | Current store key |
| cur_off | output | 32 | Current byte offset in the item |
| item_present | input | 1 | Store holds an item for `cur_key` |
| item_len | input | 32 | Length of that item |
| item_byte | input | 8 | Item byte at `cur_off` |
| busy | output | 1 | Transfer in progress |

## Verification
The sharpest same-cycle case is a new doorbell write that arrives in the very cycle the last status byte is acknowledged. In that cycle the completion and a fresh trigger meet at the same clock edge. The bench watches the memory port, lets the response to the final status byte appear, and drives an 8-byte doorbell write to a second valid descriptor in that same cycle. The outcome counts as correct only if `busy` then falls and that second descriptor is never fetched or overwritten. A stray status write lands in the scoreboard as an unexpected write. The other overlap is a select taking effect in the cycle just before the first data byte. It is judged by the bytes the scoreboard expects from offset 0 of the new item.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_PARSE, ST_MOVE, ST_STATUS
  } xfer_state_e;

  localparam int CTL_READ_BIT = 1;
  localparam int CTL_SKIP_BIT = 2;
  localparam int CTL_SEL_BIT  = 3;

  localparam int KEY_W      = 16;
  localparam int OFF_W      = 32;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;

  localparam logic [63:0] DB_IDENT = 64'h5145_4D55_2043_4647;
endpackage

// File: rtl/cfg_dma_doorbell.sv
module cfg_dma_doorbell #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [2:0]        wr_off,
  input  logic [3:0]        wr_size,
  input  logic [63:0]       wr_data,
  input  logic [2:0]        rd_off,
  input  logic [3:0]        rd_size,
  output logic [63:0]       rd_data,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  import cfg_dma_pkg::*;

  logic [63:0] held_q;
  logic        take_hi, take_lo, take_full;
  logic [63:0] go_addr;
  logic [63:0] ident_sh;
  int          span;

  always_comb begin
    take_hi   = wr_en && !busy && (wr_size == 4'd4) && (wr_off == 3'd0);
    take_lo   = wr_en && !busy && (wr_size == 4'd4) && (wr_off == 3'd4);
    take_full = wr_en && !busy && (wr_size == 4'd8) && (wr_off == 3'd0);
    start     = take_lo || take_full;
    go_addr   = take_full ? wr_data : (held_q | {32'h0, wr_data[31:0]});
    start_addr = go_addr[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       held_q <= '0;
    else if (take_hi) held_q <= {wr_data[31:0], 32'h0};
    else if (start)   held_q <= '0;
  end

  always_comb begin
    span     = int'(rd_off) + int'(rd_size);
    ident_sh = '0;
    rd_data  = '0;
    if (rd_size != 4'd0 && span <= 8) begin
      ident_sh = DB_IDENT >> (8 * (8 - span));
      for (int b = 0; b < 8; b++) begin
        if (b < int'(rd_size)) rd_data[b*8 +: 8] = ident_sh[b*8 +: 8];
      end
    end
  end

  assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (held_q == 64'h0));

  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(held_q));
endmodule

// File: rtl/cfg_dma_cursor.sv
module cfg_dma_cursor (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_en,
  input  logic [cfg_dma_pkg::KEY_W-1:0] sel_key,
  input  logic                          adv_en,
  input  logic [cfg_dma_pkg::OFF_W-1:0] adv_amt,
  output logic [cfg_dma_pkg::KEY_W-1:0] key,
  output logic [cfg_dma_pkg::OFF_W-1:0] off
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key <= '0;
      off <= '0;
    end else if (sel_en) begin
      key <= sel_key;
      off <= '0;
    end else if (adv_en) begin
      off <= off + adv_amt;
    end
  end

  assert_select_rewinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en |=> (off == '0) && (key == $past(sel_key)));
endmodule

// File: rtl/cfg_dma_xfer.sv
module cfg_dma_xfer #(
  parameter int ADDR_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             start_addr,
  output logic                          busy,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [7:0]                    mem_wdata,
  input  logic [7:0]                    mem_rdata,
  input  logic                          mem_ack,
  input  logic                          mem_err,
  input  logic [cfg_dma_pkg::OFF_W-1:0] cur_off,
  input  logic                          item_present,
  input  logic [cfg_dma_pkg::OFF_W-1:0] item_len,
  input  logic [7:0]                    item_byte,
  output logic                          sel_en,
  output logic [cfg_dma_pkg::KEY_W-1:0] sel_key,
  output logic                          adv_en,
  output logic [cfg_dma_pkg::OFF_W-1:0] adv_amt
);
  import cfg_dma_pkg::*;

  localparam int IDX_W  = $clog2(DESC_BYTES);
  localparam int DESC_W = 8 * DESC_BYTES;
  localparam logic [IDX_W-1:0] IDX_LAST_DESC = IDX_W'(DESC_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST_STAT = IDX_W'(STAT_BYTES - 1);

  xfer_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [DESC_W-1:0] desc_q;
  logic [ADDR_W-1:0] base_q, dst_q;
  logic [OFF_W-1:0] rem_q;
  logic             rd_mode_q, err_q;

  logic [31:0]      ctl_w;
  logic [OFF_W-1:0] len_w;
  logic [63:0]      dst_w;
  logic             exhausted, resp;
  logic [OFF_W-1:0] left_w, skip_amt;
  logic [31:0]      stat_word;
  logic [1:0]       stat_sel;
  logic             unused_ctl;

  assign ctl_w = desc_q[DESC_W-1 -: 32];
  assign len_w = desc_q[DESC_W-33 -: 32];
  assign dst_w = desc_q[63:0];
  assign unused_ctl = ^{ctl_w[15:4], ctl_w[0]};

  assign exhausted = !item_present || (cur_off >= item_len);
  assign left_w    = item_len - cur_off;
  assign skip_amt  = (rem_q < left_w) ? rem_q : left_w;
  assign resp      = mem_ack || mem_err;
  assign stat_word = {31'h0, err_q};
  assign stat_sel  = 2'd3 - idx_q[1:0];
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    sel_en    = 1'b0;
    sel_key   = ctl_w[31:16];
    adv_en    = 1'b0;
    adv_amt   = OFF_W'(1);
    unique case (state_q)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + ADDR_W'(idx_q);
      end
      ST_PARSE: sel_en = ctl_w[CTL_SEL_BIT];
      ST_MOVE: begin
        if (rem_q != '0) begin
          if (rd_mode_q) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_q;
            mem_wdata = exhausted ? 8'h00 : item_byte;
            adv_en    = resp && !exhausted;
          end else begin
            adv_en  = !exhausted;
            adv_amt = skip_amt;
          end
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + ADDR_W'(idx_q);
        mem_wdata = stat_word[{stat_sel, 3'b000} +: 8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      desc_q    <= '0;
      base_q    <= '0;
      dst_q     <= '0;
      rem_q     <= '0;
      rd_mode_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          base_q  <= start_addr;
          idx_q   <= '0;
          err_q   <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (mem_err) begin
            err_q   <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_STATUS;
          end else if (mem_ack) begin
            desc_q <= {desc_q[DESC_W-9:0], mem_rdata};
            idx_q  <= idx_q + 1'b1;
            if (idx_q == IDX_LAST_DESC) state_q <= ST_PARSE;
          end
        end
        ST_PARSE: begin
          dst_q     <= dst_w[ADDR_W-1:0];
          rd_mode_q <= ctl_w[CTL_READ_BIT];
          rem_q     <= (ctl_w[CTL_READ_BIT] || ctl_w[CTL_SKIP_BIT]) ? len_w : '0;
          state_q   <= ST_MOVE;
        end
        ST_MOVE: begin
          if (rem_q == '0) begin
            idx_q   <= '0;
            state_q <= ST_STATUS;
          end else if (rd_mode_q) begin
            if (resp) begin
              dst_q <= dst_q + 1'b1;
              rem_q <= rem_q - 1'b1;
            end
            if (mem_err) begin
              err_q   <= 1'b1;
              idx_q   <= '0;
              state_q <= ST_STATUS;
            end
          end else begin
            rem_q <= exhausted ? '0 : (rem_q - skip_amt);
          end
        end
        ST_STATUS: if (resp) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_LAST_STAT) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_busy_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_skip_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !mem_req) |-> !sel_en);
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_wr_en,
  input  logic [2:0]        db_wr_off,
  input  logic [3:0]        db_wr_size,
  input  logic [63:0]       db_wr_data,
  input  logic [2:0]        db_rd_off,
  input  logic [3:0]        db_rd_size,
  output logic [63:0]       db_rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [15:0]       cur_key,
  output logic [31:0]       cur_off,
  input  logic              item_present,
  input  logic [31:0]       item_len,
  input  logic [7:0]        item_byte,
  output logic              busy
);
  import cfg_dma_pkg::*;

  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic              sel_en, adv_en;
  logic [KEY_W-1:0]  sel_key;
  logic [OFF_W-1:0]  adv_amt;

  cfg_dma_doorbell #(.ADDR_W(ADDR_W)) u_bell (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .wr_en(db_wr_en), .wr_off(db_wr_off), .wr_size(db_wr_size), .wr_data(db_wr_data),
    .rd_off(db_rd_off), .rd_size(db_rd_size), .rd_data(db_rd_data),
    .start(start), .start_addr(start_addr)
  );

  cfg_dma_cursor u_cursor (
    .clk(clk), .rst_n(rst_n),
    .sel_en(sel_en), .sel_key(sel_key), .adv_en(adv_en), .adv_amt(adv_amt),
    .key(cur_key), .off(cur_off)
  );

  cfg_dma_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .cur_off(cur_off), .item_present(item_present), .item_len(item_len),
    .item_byte(item_byte), .sel_en(sel_en), .sel_key(sel_key),
    .adv_en(adv_en), .adv_amt(adv_amt)
  );
endmodule

// File: tb/cfg_dma_engine_tb_top.sv
module cfg_dma_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        db_wr_en = 1'b0;
  logic [2:0]  db_wr_off = '0;
  logic [3:0]  db_wr_size = '0;
  logic [63:0] db_wr_data = '0;
  logic [2:0]  db_rd_off = '0;
  logic [3:0]  db_rd_size = '0;
  logic [63:0] db_rd_data;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [15:0] cur_key;
  logic [31:0] cur_off;
  logic        item_present;
  logic [31:0] item_len;
  logic [7:0]  item_byte;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_dma_engine dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ib(input logic [15:0] k, input logic [31:0] o);
    case (k)
      16'd0: ib = (o == 0) ? 8'h51 : (o == 1) ? 8'h45 : (o == 2) ? 8'h4D : 8'h55;
      16'd1: ib = 8'hA0 + o[7:0];
      16'd3: ib = 8'h30 + o[7:0];
      default: ib = 8'h00;
    endcase
  endfunction

  always_comb begin
    item_byte = ib(cur_key, cur_off);
    case (cur_key)
      16'd0: begin item_present = 1'b1; item_len = 32'd4;  end
      16'd1: begin item_present = 1'b1; item_len = 32'd10; end
      16'd3: begin item_present = 1'b1; item_len = 32'd3;  end
      default: begin item_present = 1'b0; item_len = 32'd0; end
    endcase
  end

  // memory model and scoreboard monitor
  typedef struct packed { logic [63:0] a; logic [7:0] d; } ev_t;
  ev_t exp_q[$];
  logic [7:0] mem [0:4095];
  int   lat = 0, lat_cnt = 0;
  bit   pend = 0, mm_prev;
  logic [63:0] held_a;

  function automatic bit faulty(input logic [63:0] a);
    faulty = (a >= 64'h1000) || (a >= 64'hF0C && a <= 64'hF0F);
  endfunction

  always @(negedge clk) begin
    mm_prev = mem_ack || mem_err;
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (rst_n && mem_req && !mm_prev) begin
      if (!pend) begin pend = 1; lat_cnt = 0; held_a = mem_addr; end
      if (lat_cnt >= lat) begin
        pend = 0;
        chk(mem_addr == held_a, "R12 address held across stall", mem_addr, held_a);
        if (faulty(mem_addr)) mem_err = 1'b1;
        else begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[11:0]] = mem_wdata;
            if (exp_q.size() == 0)
              chk(1'b0, "R4/R8 unexpected write", {mem_addr[55:0], mem_wdata}, 64'h0);
            else begin
              ev_t e;
              e = exp_q.pop_front();
              chk(e.a == mem_addr && e.d == mem_wdata, "R8/R10/R11 write stream",
                  {mem_addr[55:0], mem_wdata}, {e.a[55:0], e.d});
            end
          end else mem_rdata = mem[mem_addr[11:0]];
        end
      end else lat_cnt++;
    end
  end

  task automatic put_desc(input int base, input logic [31:0] c, input logic [31:0] l, input logic [63:0] d);
    logic [127:0] w;
    w = {c, l, d};
    for (int i = 0; i < 16; i++) mem[base + i] = w[127 - 8*i -: 8];
  endtask

  task automatic expect_b(input logic [63:0] a, input logic [7:0] d);
    ev_t e;
    e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic expect_status(input logic [63:0] base, input logic [7:0] s);
    for (int i = 0; i < 3; i++) expect_b(base + i, 8'h00);
    expect_b(base + 3, s);
  endtask

  task automatic db_write(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    db_wr_en = 1'b1; db_wr_off = off; db_wr_size = sz; db_wr_data = d;
    @(negedge clk);
    db_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(!busy, "R13 busy drops after status", {63'h0, busy}, 64'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic sb_empty(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic rd_ident(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] exp);
    @(negedge clk);
    db_rd_off = off; db_rd_size = sz;
    #1 chk(db_rd_data == exp, "R3 identification read", db_rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);
    chk(cur_key == 0 && cur_off == 0, "R1 cursor after reset", {cur_key, cur_off}, 0);

    // R3
    rd_ident(3'd0, 4'd8, 64'h5145_4D55_2043_4647);
    rd_ident(3'd4, 4'd4, 64'h2043_4647);
    rd_ident(3'd0, 4'd1, 64'h51);
    rd_ident(3'd6, 4'd2, 64'h4647);
    rd_ident(3'd5, 4'd4, 64'h0);

    // R2 R5 R6 R8 split doorbell, select key 1, read 6
    put_desc(32'h800, 32'h0001_000A, 32'd6, 64'h200);
    for (int i = 0; i < 6; i++) expect_b(64'h200 + i, 8'hA0 + 8'(i));
    expect_status(64'h800, 8'h00);
    db_write(3'd0, 4'd4, 64'h0);
    chk(!busy, "R2 upper half does not start", busy, 0);
    db_write(3'd4, 4'd4, 64'h800);
    chk(busy, "R13 busy after trigger", busy, 1);
    wait_idle();
    sb_empty("R8 read stream complete");
    chk(cur_key == 1 && cur_off == 6, "R6/R8 cursor after read", {cur_key, cur_off}, {16'd1, 32'd6});

    // R10 read runs past item end: 4 data then 4 zeros
    put_desc(32'h840, 32'h0000_0002, 32'd8, 64'h300);
    for (int i = 0; i < 4; i++) expect_b(64'h300 + i, 8'hA6 + 8'(i));
    for (int i = 4; i < 8; i++) expect_b(64'h300 + i, 8'h00);
    expect_status(64'h840, 8'h00);
    db_write(3'd0, 4'd8, 64'h840);
    wait_idle();
    sb_empty("R10 zero fill");
    chk(cur_off == 10, "R10 offset stops at end", cur_off, 10);

    // R9 skip with select
    put_desc(32'h880, 32'h0001_000C, 32'd3, 64'h380);
    expect_status(64'h880, 8'h00);
    db_write(3'd0, 4'd8, 64'h880);
    wait_idle();
    chk(cur_off == 3, "R9 skip advance", cur_off, 3);
    // R7 read wins over skip
    put_desc(32'h8C0, 32'h0000_0006, 32'd2, 64'h390);
    expect_b(64'h390, 8'hA3); expect_b(64'h391, 8'hA4);
    expect_status(64'h8C0, 8'h00);
    db_write(3'd0, 4'd8, 64'h8C0);
    wait_idle();
    chk(cur_off == 5, "R7 read priority", cur_off, 5);
    // R9/R10 skip longer than item
    put_desc(32'h900, 32'h0000_0004, 32'd20, 64'h3A0);
    expect_status(64'h900, 8'h00);
    db_write(3'd0, 4'd8, 64'h900);
    wait_idle();
    chk(cur_off == 10, "R9 skip clamps to item", cur_off, 10);

    // R7 neither bit: select only
    put_desc(32'h940, 32'h0003_0008, 32'd5, 64'h3B0);
    expect_status(64'h940, 8'h00);
    db_write(3'd0, 4'd8, 64'h940);
    wait_idle();
    chk(cur_key == 3 && cur_off == 0, "R7 no move without mode", {cur_key, cur_off}, {16'd3, 32'd0});

    // R10 absent item
    put_desc(32'h980, 32'h0002_000A, 32'd3, 64'h400);
    for (int i = 0; i < 3; i++) expect_b(64'h400 + i, 8'h00);
    expect_status(64'h980, 8'h00);
    db_write(3'd0, 4'd8, 64'h980);
    wait_idle();
    sb_empty("R10 absent item zero fill");
    chk(cur_off == 0, "R10 offset frozen on absent", cur_off, 0);

    // R11 fetch error
    put_desc(32'hF00, 32'h0001_000A, 32'd4, 64'h410);
    expect_status(64'hF00, 8'h01);
    db_write(3'd0, 4'd8, 64'hF00);
    wait_idle();
    sb_empty("R11 fetch error status");
    chk(cur_key == 2, "R11 cursor untouched by failed fetch", cur_key, 2);

    // R11 write error at 0x1000
    put_desc(32'h9C0, 32'h0001_000A, 32'd4, 64'hFFE);
    expect_b(64'hFFE, 8'hA0); expect_b(64'hFFF, 8'hA1);
    expect_status(64'h9C0, 8'h01);
    db_write(3'd0, 4'd8, 64'h9C0);
    wait_idle();
    sb_empty("R11 write error status");
    chk(cur_off == 3, "R11 failed byte advances offset", cur_off, 3);

    // R4 stored address cleared at start: low-half only goes to 0xA40
    put_desc(32'hA00, 32'h0, 32'd0, 64'h0);
    put_desc(32'hA40, 32'h0, 32'd0, 64'h0);
    expect_status(64'hA00, 8'h00);
    db_write(3'd0, 4'd4, 64'h0);
    db_write(3'd4, 4'd4, 64'hA00);
    wait_idle();
    expect_status(64'hA40, 8'h00);
    db_write(3'd4, 4'd4, 64'hA40);
    wait_idle();
    sb_empty("R4 address cleared");

    // R2 malformed doorbell writes
    db_write(3'd2, 4'd4, 64'h800);
    db_write(3'd0, 4'd2, 64'h800);
    db_write(3'd4, 4'd8, 64'h800);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 malformed writes ignored", busy, 0);

    // R4/R13 writes while busy, including final-ack cycle
    lat = 2;
    put_desc(32'hA80, 32'h0001_000A, 32'd2, 64'h500);
    put_desc(32'hAC0, 32'h0, 32'd0, 64'h0);
    expect_b(64'h500, 8'hA0); expect_b(64'h501, 8'hA1);
    expect_status(64'hA80, 8'h00);
    db_write(3'd0, 4'd8, 64'hA80);
    db_write(3'd0, 4'd8, 64'hAC0);
    forever begin
      @(negedge clk);
      #1 if (mem_ack && mem_we && mem_addr == 64'hA83) break;
    end
    db_wr_en = 1'b1; db_wr_off = 3'd0; db_wr_size = 4'd8; db_wr_data = 64'hAC0;
    @(posedge clk);
    #1 db_wr_en = 1'b0;
    @(negedge clk);
    chk(!busy, "R4 trigger in completion cycle ignored", busy, 0);
    repeat (20) @(negedge clk);
    chk(!busy && !mem_req, "R13 stays idle", {busy, mem_req}, 0);
    sb_empty("R4 busy writes ignored");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule